// File: doc/BRIEF.md
# SIMD Divergence Mask Stack

This block keeps the lane execution mask of one SIMD thread while that thread walks through nested if/else/endif control flow. When the lanes of the thread disagree on a branch condition, the taken path and the not-taken path are run one after the other. Each path runs under its own mask, and the mask that was live before the branch is restored once both paths are done. A saved-mask stack tracks nesting, so divergence inside an inner branch can only narrow the set of lanes that were live in the enclosing branch.

The control sequencer presents one control opcode per clock, together with the per-lane condition vector for that opcode. The block registers the resulting liveness mask, which the execution lanes use to gate their writes. It also raises a skip flag when the path just entered has no live lane, so the sequencer can jump over that path. The logical SIMD width is set per thread with a width opcode, which also starts a fresh thread context. Lanes above the selected width never go live. Pushing onto a full stack sets a sticky overflow flag, and popping an empty stack sets a sticky underflow flag. Neither fault changes the mask.

Top module: `simd_mask_stack`

## Requirements
- R1: After reset the width is 32 lanes, `active_mask` is all ones, and `skip`, `overflow` and `underflow` are 0.
- R2: Opcode 4 (set width) takes code w from `width_code` and makes the lowest 2^w lanes live, with w = 0..5. Codes 6 and 7 select 32 lanes. The opcode also empties the stack and clears `skip`, `overflow` and `underflow`, and the new mask shows one cycle later.
- R3: Opcode 1 (if) saves the current mask and, one cycle later, sets `active_mask` to the old mask AND `cond`.
- R4: Opcode 2 (else) sets `active_mask` to the mask saved by the innermost open if, AND NOT `cond`.
- R5: Opcode 3 (endif) restores the mask saved by the innermost open if and closes that level.
- R6: Nested levels restore in last-in first-out order, and an inner if or else never activates a lane that was inactive in the enclosing level.
- R7: Lanes at or above the selected width stay 0 in `active_mask`, whatever `cond` holds.
- R8: `skip` is 1 in the cycle after an accepted if or else exactly when the new mask is all zero. An accepted endif or set-width clears it.
- R9: When every live lane has `cond` = 1, an if leaves the mask unchanged, and the following else yields an all-zero mask with `skip` = 1.
- R10: An if issued while 8 levels are open leaves the mask unchanged and sets `overflow`. The flag stays set until a set-width opcode.
- R11: An else or endif issued with no level open leaves the mask unchanged and sets `underflow`. The flag stays set until a set-width opcode.
- R12: Opcode 0 and the unused codes 5..7 leave the mask and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Control opcode: 0 none, 1 if, 2 else, 3 endif, 4 set width |
| width_code | input | 3 | log2 of the lane count, used with opcode 4 |
| cond | input | 32 | Per-lane branch condition, used with if and else |
| active_mask | output | 32 | Registered liveness mask, bit i for lane i |
| skip | output | 1 | Path just entered has no live lane |
| overflow | output | 1 | Sticky: if issued with the stack full |
| underflow | output | 1 | Sticky: else or endif issued with the stack empty |

## Verification
The bench applies a half-split condition, which separates AND from AND NOT and checks that else really uses the saved mask. Two-deep interleaved patterns show whether inner masks stay inside outer ones and whether the restore order is last-in first-out. All-ones and all-zero conditions, run under a narrowed width, expose leakage above the width and check that `skip` follows a uniform branch. Nine-deep nesting and closes issued on an empty stack show whether a fault leaves the mask untouched and whether its flag stays set.

// File: rtl/simd_mask_pkg.sv
`timescale 1ns/1ps
package simd_mask_pkg;
   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_IF    = 3'd1,
      OP_ELSE  = 3'd2,
      OP_ENDIF = 3'd3,
      OP_SETW  = 3'd4
   } mask_op_e;
endpackage

// File: rtl/simd_lane_limit.sv
`timescale 1ns/1ps
module simd_lane_limit #(
   parameter int MAX_LOG2 = 5,
   localparam int LANES = 1 << MAX_LOG2
) (
   input  logic [2:0]       wcode,
   output logic [LANES-1:0] limit
);
   logic [2:0] eff;
   assign eff = (wcode > 3'(MAX_LOG2)) ? 3'(MAX_LOG2) : wcode;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int NEED = $clog2(g + 1);
      assign limit[g] = (int'(eff) >= NEED);
   end
endmodule

// File: rtl/simd_saved_stack.sv
`timescale 1ns/1ps
module simd_saved_stack #(
   parameter int LANES = 32,
   parameter int DEPTH = 8,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             clear,
   input  logic [LANES-1:0] push_data,
   output logic [LANES-1:0] top_data,
   output logic             full,
   output logic             empty
);
   logic [LANES-1:0] mem [DEPTH];
   logic [CW-1:0]    cnt;

   assign full     = (cnt == CW'(DEPTH));
   assign empty    = (cnt == '0);
   assign top_data = mem[AW'(cnt - CW'(1))];

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt <= '0;
      end else if (push && !full) begin
         cnt <= cnt + CW'(1);
      end else if (pop && !empty) begin
         cnt <= cnt - CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem[AW'(cnt)] <= push_data;
   end
endmodule

// File: rtl/simd_mask_stack.sv
`timescale 1ns/1ps
module simd_mask_stack
   import simd_mask_pkg::*;
#(
   parameter int MAX_LOG2 = 5,
   parameter int DEPTH    = 8,
   localparam int LANES   = 1 << MAX_LOG2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       op,
   input  logic [2:0]       width_code,
   input  logic [LANES-1:0] cond,
   output logic [LANES-1:0] active_mask,
   output logic             skip,
   output logic             overflow,
   output logic             underflow
);
   if (MAX_LOG2 < 0 || MAX_LOG2 > 5) begin : g_bad_width
      $error("simd_mask_stack: MAX_LOG2 must lie in 0..5");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("simd_mask_stack: DEPTH must be at least 1");
   end

   logic [2:0]       wcode_q, wcode_n;
   logic [LANES-1:0] lim_cur, lim_new;
   logic [LANES-1:0] act_n, top_mask, if_mask, else_mask;
   logic             skip_n, ovf_n, udf_n;
   logic             stk_push, stk_pop, stk_clear, stk_full, stk_empty;
   mask_op_e         opc;

   assign opc = mask_op_e'(op);

   simd_lane_limit #(.MAX_LOG2(MAX_LOG2)) u_lim_cur (
      .wcode (wcode_q),
      .limit (lim_cur)
   );
   simd_lane_limit #(.MAX_LOG2(MAX_LOG2)) u_lim_new (
      .wcode (width_code),
      .limit (lim_new)
   );

   simd_saved_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (stk_push),
      .pop       (stk_pop),
      .clear     (stk_clear),
      .push_data (active_mask),
      .top_data  (top_mask),
      .full      (stk_full),
      .empty     (stk_empty)
   );

   assign if_mask   = active_mask & cond & lim_cur;
   assign else_mask = top_mask & ~cond & lim_cur;

   always_comb begin
      act_n     = active_mask;
      wcode_n   = wcode_q;
      skip_n    = skip;
      ovf_n     = overflow;
      udf_n     = underflow;
      stk_push  = 1'b0;
      stk_pop   = 1'b0;
      stk_clear = 1'b0;
      case (opc)
         OP_IF: begin
            if (stk_full) begin
               ovf_n = 1'b1;
            end else begin
               stk_push = 1'b1;
               act_n    = if_mask;
               skip_n   = (if_mask == '0);
            end
         end
         OP_ELSE: begin
            if (stk_empty) begin
               udf_n = 1'b1;
            end else begin
               act_n  = else_mask;
               skip_n = (else_mask == '0);
            end
         end
         OP_ENDIF: begin
            if (stk_empty) begin
               udf_n = 1'b1;
            end else begin
               stk_pop = 1'b1;
               act_n   = top_mask;
               skip_n  = 1'b0;
            end
         end
         OP_SETW: begin
            stk_clear = 1'b1;
            wcode_n   = width_code;
            act_n     = lim_new;
            skip_n    = 1'b0;
            ovf_n     = 1'b0;
            udf_n     = 1'b0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcode_q     <= 3'(MAX_LOG2);
         active_mask <= '1;
         skip        <= 1'b0;
         overflow    <= 1'b0;
         underflow   <= 1'b0;
      end else begin
         wcode_q     <= wcode_n;
         active_mask <= act_n;
         skip        <= skip_n;
         overflow    <= ovf_n;
         underflow   <= udf_n;
      end
   end
endmodule

// File: rtl/simd_mask_stack_chk.sv
`timescale 1ns/1ps
module simd_mask_stack_chk
   import simd_mask_pkg::*;
#(
   parameter int MAX_LOG2 = 5,
   localparam int LANES   = 1 << MAX_LOG2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       op,
   input logic [2:0]       width_code,
   input logic [LANES-1:0] active_mask,
   input logic             skip,
   input logic             overflow,
   input logic             underflow,
   input logic             stk_full,
   input logic             stk_empty
);
   logic [2:0]       wq;
   logic [LANES-1:0] lim;

   always_ff @(posedge clk) begin
      if (!rst_n) wq <= 3'(MAX_LOG2);
      else if (op == OP_SETW)
         wq <= (width_code > 3'(MAX_LOG2)) ? 3'(MAX_LOG2) : width_code;
   end

   always_comb begin
      for (int i = 0; i < LANES; i++) lim[i] = (i < (1 << wq));
   end

   AST_LANE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (active_mask & ~lim) == '0); // R7

   AST_IF_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_IF && !stk_full) |=> ((active_mask & ~$past(active_mask)) == '0)); // R3

   AST_SKIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((op == OP_IF && !stk_full) || (op == OP_ELSE && !stk_empty))
      |=> (skip == (active_mask == '0))); // R8

   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_IF && stk_full) |=> (overflow && $stable(active_mask))); // R10

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && op != OP_SETW) |=> overflow); // R10

   AST_UDF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ((op == OP_ENDIF || op == OP_ELSE) && stk_empty)
      |=> (underflow && $stable(active_mask))); // R11

   AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_NONE) |=> ($stable(active_mask) && $stable(skip))); // R12
endmodule

bind simd_mask_stack simd_mask_stack_chk #(.MAX_LOG2(MAX_LOG2)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op          (op),
   .width_code  (width_code),
   .active_mask (active_mask),
   .skip        (skip),
   .overflow    (overflow),
   .underflow   (underflow),
   .stk_full    (stk_full),
   .stk_empty   (stk_empty)
);

// File: tb/simd_mask_stack_tb_top.sv
`timescale 1ns/1ps
module simd_mask_stack_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [2:0]  width_code = 3'd0;
   logic [31:0] cond = '0;
   logic [31:0] active_mask;
   logic        skip, overflow, underflow;
   int          checks = 0;
   int          failures = 0;

   always #4 clk = ~clk;

   simd_mask_stack dut_i (
      .clk(clk), .rst_n(rst_n), .op(op), .width_code(width_code), .cond(cond),
      .active_mask(active_mask), .skip(skip), .overflow(overflow), .underflow(underflow)
   );

   task automatic chk(input string req, input logic [31:0] em,
                      input logic es, input logic eo, input logic eu);
      checks++;
      if ({active_mask, skip, overflow, underflow} !== {em, es, eo, eu}) begin
         failures++;
         $display("FAIL %s: mask=%h skip=%b ovf=%b udf=%b expected mask=%h skip=%b ovf=%b udf=%b",
                  req, active_mask, skip, overflow, underflow, em, es, eo, eu);
      end
   endtask

   // drive one opcode for one edge, sample at the following falling edge
   task automatic issue(input logic [2:0] o, input logic [31:0] c, input logic [2:0] w);
      @(negedge clk);
      op = o; cond = c; width_code = w;
      @(negedge clk);
      op = 3'd0; cond = '0; width_code = 3'd0;
   endtask

   task automatic t_reset;
      chk("R1 reset state", 32'hFFFF_FFFF, 0, 0, 0);
   endtask

   task automatic t_if_else;
      issue(3'd1, 32'h0000_FFFF, 0); chk("R3 if ANDs cond", 32'h0000_FFFF, 0, 0, 0);
      issue(3'd2, 32'h0000_FFFF, 0); chk("R4 else uses saved mask", 32'hFFFF_0000, 0, 0, 0);
      issue(3'd3, 32'h0, 0);         chk("R5 endif restores", 32'hFFFF_FFFF, 0, 0, 0);
   endtask

   task automatic t_nested;
      issue(3'd1, 32'h00FF_00FF, 0); chk("R6 outer if", 32'h00FF_00FF, 0, 0, 0);
      issue(3'd1, 32'h0F0F_0F0F, 0); chk("R6 inner if within outer", 32'h000F_000F, 0, 0, 0);
      issue(3'd2, 32'h0F0F_0F0F, 0); chk("R6 inner else within outer", 32'h00F0_00F0, 0, 0, 0);
      issue(3'd3, 32'h0, 0);         chk("R6 pop inner level", 32'h00FF_00FF, 0, 0, 0);
      issue(3'd3, 32'h0, 0);         chk("R6 pop outer level", 32'hFFFF_FFFF, 0, 0, 0);
   endtask

   task automatic t_width;
      issue(3'd4, 32'h0, 3'd3);      chk("R2 width 8", 32'h0000_00FF, 0, 0, 0);
      issue(3'd1, 32'hFFFF_FFFF, 0); chk("R7 R9 uniform if keeps mask", 32'h0000_00FF, 0, 0, 0);
      issue(3'd2, 32'hFFFF_FFFF, 0); chk("R9 R8 uniform else skipped", 32'h0000_0000, 1, 0, 0);
      issue(3'd3, 32'h0, 0);         chk("R8 endif clears skip", 32'h0000_00FF, 0, 0, 0);
      issue(3'd2, 32'h0, 0);         chk("R7 else beyond width stays 0", 32'h0000_00FF, 0, 0, 1);
      issue(3'd4, 32'h0, 3'd0);      chk("R2 width 1 clears flags", 32'h0000_0001, 0, 0, 0);
      issue(3'd4, 32'h0, 3'd7);      chk("R2 code 7 gives 32", 32'hFFFF_FFFF, 0, 0, 0);
      issue(3'd4, 32'h0, 3'd5);      chk("R2 width 32", 32'hFFFF_FFFF, 0, 0, 0);
   endtask

   task automatic t_skip;
      issue(3'd1, 32'h0, 0);         chk("R8 empty if sets skip", 32'h0, 1, 0, 0);
      issue(3'd2, 32'h0, 0);         chk("R8 full else clears skip", 32'hFFFF_FFFF, 0, 0, 0);
      issue(3'd3, 32'h0, 0);         chk("R5 endif after skip", 32'hFFFF_FFFF, 0, 0, 0);
   endtask

   task automatic t_nop;
      issue(3'd1, 32'h1234_5678, 0); chk("R3 if before hold", 32'h1234_5678, 0, 0, 0);
      issue(3'd0, 32'hFFFF_0000, 0); chk("R12 opcode 0 holds", 32'h1234_5678, 0, 0, 0);
      issue(3'd5, 32'h0, 3'd1);      chk("R12 opcode 5 holds", 32'h1234_5678, 0, 0, 0);
      issue(3'd7, 32'h0, 3'd2);      chk("R12 opcode 7 holds", 32'h1234_5678, 0, 0, 0);
      issue(3'd3, 32'h0, 0);         chk("R5 endif after hold", 32'hFFFF_FFFF, 0, 0, 0);
   endtask

   task automatic t_overflow;
      for (int i = 0; i < 8; i++) issue(3'd1, 32'hFFFF_FFFF, 0);
      chk("R10 eight levels fine", 32'hFFFF_FFFF, 0, 0, 0);
      issue(3'd1, 32'h0, 0);         chk("R10 ninth if overflows", 32'hFFFF_FFFF, 0, 1, 0);
      issue(3'd3, 32'h0, 0);         chk("R10 overflow sticky", 32'hFFFF_FFFF, 0, 1, 0);
      issue(3'd4, 32'h0, 3'd5);      chk("R10 R2 set width clears", 32'hFFFF_FFFF, 0, 0, 0);
   endtask

   task automatic t_underflow;
      issue(3'd1, 32'h0000_00F0, 0); issue(3'd3, 32'h0, 0);
      issue(3'd3, 32'h0, 0);         chk("R11 endif on empty", 32'hFFFF_FFFF, 0, 0, 1);
      issue(3'd1, 32'h0000_000F, 0); chk("R11 underflow sticky", 32'h0000_000F, 0, 0, 1);
      issue(3'd4, 32'h0, 3'd5);      chk("R11 R2 set width clears", 32'hFFFF_FFFF, 0, 0, 0);
   endtask

   initial begin
      #(8 * 100000);
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_if_else();
      t_nested();
      t_width();
      t_skip();
      t_nop();
      t_overflow();
      t_underflow();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule